// File: doc/BRIEF.md
# UART receive FIFO with trigger level

This block is the receive-side character store of a serial port. Characters arrive from the deserializer, or from the local transmit path when loopback is selected. Each one is kept together with its per-character error flags. Software drains the store through reads of the data register. Every read shows the oldest entry and moves it into a sticky receive-status register.

The store runs in one of two modes. With the FIFO enabled it holds `DEPTH` entries, 16 by default. With the FIFO disabled it becomes a single holding register. A configuration write that changes the enable bit empties the store and pulses a flush towards the transmit side. A raw receive interrupt is set when a push brings the occupancy to the trigger level, and cleared when a read leaves it one below that level. A ready output lets the deserializer hold off while no slot is free.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, rx_empty=1, rx_full=0, rx_irq=0, rx_stat=0, and the store is in single-entry mode (FIFO disabled).
- R2: The capacity is DEPTH (16) entries with the FIFO enabled and 1 entry with it disabled. rx_empty is high when no entry is held, rx_full is high when the count equals the capacity, and rx_ready is high exactly while the count is below the capacity.
- R3: Accepted characters are returned in arrival order. The 12-bit entry layout is: bits 7:0 data, bit 8 framing error (rx_err[0]), bit 9 parity error (rx_err[1]), bit 10 break, bit 11 overrun.
- R4: A push while the store is full (and not read in the same cycle) is discarded, and bit 11 of the newest stored entry is set.
- R5: While rd_en is high and the store is not empty, rd_data shows the oldest entry in that cycle, and that entry is removed at the clock edge. A read of an empty store changes neither the contents nor rx_stat.
- R6: A read of a non-empty store loads bits 11:8 of the entry into rx_stat. stat_clr zeroes rx_stat. If a clear and a capture fall in the same cycle, the capture wins.
- R7: A push that makes the count equal TRIG (1) sets rx_irq. A read after which count+1 equals TRIG clears it, and so does irq_clr. A set in the same cycle wins over both clears.
- R8: A cfg_wr whose cfg_fifo_en differs from the current mode switches the mode, empties the store and pulses tx_flush in that cycle. The flush overrides any push or read in the same cycle. A cfg_wr that repeats the current mode has no effect.
- R9: With lb_en high, each tx_valid pushes tx_data with all error bits zero, and rx_valid and rx_brk are ignored.
- R10: With lb_en low, rx_brk pushes the word 0x400 (data zero, break bit 10 set) and takes priority over rx_valid in the same cycle.
- R11: A read and a push in the same cycle are applied as read first, then push, so a full store accepts the new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Deserializer presents a character |
| rx_data | input | 8 | Received character |
| rx_err | input | 2 | {parity error, framing error} for the character |
| rx_brk | input | 1 | A line break was received |
| lb_en | input | 1 | Loopback select: the transmit path feeds the store |
| tx_valid | input | 1 | Transmit path writes a character |
| tx_data | input | 8 | Transmitted character |
| rx_ready | output | 1 | A free slot exists |
| cfg_wr | input | 1 | Line-control write strobe |
| cfg_fifo_en | input | 1 | FIFO enable value carried by the write |
| rd_en | input | 1 | Data-register read |
| rd_data | output | 12 | Oldest entry with its error bits |
| stat_clr | input | 1 | Write to the receive-status register (clears it) |
| rx_stat | output | 4 | Error bits of the last read entry {overrun, break, parity, framing} |
| irq_clr | input | 1 | Clear the raw receive interrupt |
| rx_irq | output | 1 | Raw receive interrupt status |
| rx_empty | output | 1 | Store empty |
| rx_full | output | 1 | Store full |
| tx_flush | output | 1 | Pulse: FIFO mode changed, transmit flags must reset |

## Verification
The bench pushes the store past capacity in both modes. A design that wraps the write slot instead of dropping would overwrite the oldest character, and a design that marks the wrong slot would put the overrun bit on an entry that was not the newest. Reads and pushes collide in the same cycle while the store is full, and a wrong ordering either refuses a character or loses one. Mode changes are mixed with pushes and reads in the same cycle; a design that lets those through would leave stale entries after the flush. Empty-store reads, reads that coincide with status clears, and the trigger edges on fill and on drain are exercised throughout.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
    localparam int DATA_W  = 8;
    localparam int WORD_W  = 12;
    localparam int FE_BIT  = 8;
    localparam int PE_BIT  = 9;
    localparam int BRK_BIT = 10;
    localparam int OVR_BIT = 11;
    localparam int STAT_W  = OVR_BIT - FE_BIT + 1;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/uart_rx_fifo_src.sv
module uart_rx_fifo_src
    import uart_rx_fifo_pkg::*;
(
    input  logic              lb_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [1:0]        rx_err,
    input  logic              rx_brk,
    output logic              push_req,
    output word_t             push_word
);
    always_comb begin
        push_req  = 1'b0;
        push_word = '0;
        if (lb_en) begin
            push_req  = tx_valid;
            push_word = {{(WORD_W-DATA_W){1'b0}}, tx_data};
        end else if (rx_brk) begin
            push_req           = 1'b1;
            push_word          = '0;
            push_word[BRK_BIT] = 1'b1;
        end else begin
            push_req           = rx_valid;
            push_word          = {{(WORD_W-DATA_W){1'b0}}, rx_data};
            push_word[FE_BIT]  = rx_err[0];
            push_word[PE_BIT]  = rx_err[1];
        end
    end
endmodule

// File: rtl/uart_rx_fifo_store.sv
module uart_rx_fifo_store
    import uart_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_word,
    input  logic          mark_en,
    input  logic [AW-1:0] mark_addr,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_word
);
    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_word;
        end else if (mark_en) begin
            mem_q[mark_addr][OVR_BIT] <= 1'b1;
        end
    end

    assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl
    import uart_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fen_wr,
    input  logic              fen_val,
    input  logic              push_req,
    input  word_t             push_word,
    input  logic              rd_en,
    input  word_t             head_word,
    input  logic              stat_clr,
    input  logic              irq_clr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output word_t             wr_word,
    output logic              mark_en,
    output logic [AW-1:0]     mark_addr,
    output logic [AW-1:0]     rd_addr,
    output logic [CW-1:0]     cnt,
    output logic              fen,
    output logic              flush,
    output logic              ready,
    output logic              empty,
    output logic              full,
    output logic              irq,
    output logic [STAT_W-1:0] stat
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] TRIG_C  = CW'(TRIG);
    localparam logic [CW:0]   TRIG_X  = (CW+1)'(TRIG);

    typedef struct packed {
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     cnt;
        logic              empty;
        logic              full;
        logic              irq;
        logic              fen;
        logic [STAT_W-1:0] stat;
    } state_t;

    state_t st_d, st_q;
    logic [CW-1:0] depth_cur;
    logic [AW-1:0] mask;

    assign depth_cur = st_q.fen ? DEPTH_C : CW'(1);
    assign mask      = AW'(depth_cur - 1'b1);

    always_comb begin
        st_d      = st_q;
        wr_en     = 1'b0;
        wr_addr   = '0;
        mark_en   = 1'b0;
        mark_addr = '0;
        flush     = 1'b0;
        if (stat_clr) st_d.stat = '0;
        if (irq_clr)  st_d.irq  = 1'b0;
        if (fen_wr && (fen_val != st_q.fen)) begin
            flush     = 1'b1;
            st_d.fen  = fen_val;
            st_d.rptr = '0;
            st_d.cnt  = '0;
        end else begin
            if (rd_en) begin
                if (st_q.cnt != '0) begin
                    st_d.stat = head_word[OVR_BIT:FE_BIT];
                    st_d.cnt  = st_q.cnt - 1'b1;
                    st_d.rptr = (st_q.rptr + 1'b1) & mask;
                end
                if (({1'b0, st_d.cnt} + 1'b1) == TRIG_X) st_d.irq = 1'b0;
            end
            if (push_req) begin
                if (st_d.cnt < depth_cur) begin
                    wr_en    = 1'b1;
                    wr_addr  = (st_d.rptr + st_d.cnt[AW-1:0]) & mask;
                    st_d.cnt = st_d.cnt + 1'b1;
                    if (st_d.cnt == TRIG_C) st_d.irq = 1'b1;
                end else begin
                    mark_en   = 1'b1;
                    mark_addr = (st_d.rptr + st_d.cnt[AW-1:0] - 1'b1) & mask;
                end
            end
        end
        st_d.empty = (st_d.cnt == '0);
        st_d.full  = (st_d.cnt == depth_cur);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_word = push_word;
    assign rd_addr = st_q.rptr;
    assign cnt     = st_q.cnt;
    assign fen     = st_q.fen;
    assign ready   = st_q.cnt < depth_cur;
    assign empty   = st_q.empty;
    assign full    = st_q.full;
    assign irq     = st_q.irq;
    assign stat    = st_q.stat;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [1:0]        rx_err,
    input  logic              rx_brk,
    input  logic              lb_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_ready,
    input  logic              cfg_wr,
    input  logic              cfg_fifo_en,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              stat_clr,
    output logic [STAT_W-1:0] rx_stat,
    input  logic              irq_clr,
    output logic              rx_irq,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              tx_flush
);
    logic          src_req;
    word_t         src_word;
    logic          wr_en, mark_en;
    logic [AW-1:0] wr_addr, mark_addr, rd_addr;
    word_t         wr_word, head_word;
    logic [CW-1:0] ctl_cnt;
    logic          ctl_fen;

    uart_rx_fifo_src u_src (
        .lb_en(lb_en), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .rx_brk(rx_brk),
        .push_req(src_req), .push_word(src_word)
    );

    uart_rx_fifo_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fen_wr(cfg_wr), .fen_val(cfg_fifo_en),
        .push_req(src_req), .push_word(src_word),
        .rd_en(rd_en), .head_word(head_word),
        .stat_clr(stat_clr), .irq_clr(irq_clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
        .mark_en(mark_en), .mark_addr(mark_addr), .rd_addr(rd_addr),
        .cnt(ctl_cnt), .fen(ctl_fen), .flush(tx_flush), .ready(rx_ready),
        .empty(rx_empty), .full(rx_full), .irq(rx_irq), .stat(rx_stat)
    );

    uart_rx_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
        .mark_en(mark_en), .mark_addr(mark_addr),
        .rd_addr(rd_addr), .rd_word(head_word)
    );

    assign rd_data = head_word;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt,
    input logic          fen,
    input logic          push_req,
    input logic          rd_en,
    input logic          flush,
    input logic          rx_empty,
    input logic          rx_full,
    input logic          rx_irq,
    input logic [11:0]   rd_data,
    input logic [3:0]    rx_stat
);
    assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (fen ? CW'(DEPTH) : CW'(1)));

    assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && rx_full && !rd_en && !flush) |=> $stable(cnt));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rx_empty && cnt == '0));

    assert_irq_rise_at_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> (cnt == CW'(TRIG)));

    assert_stat_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cnt != '0 && !flush) |=> (rx_stat == $past(rd_data[11:8])));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .TRIG(TRIG)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(ctl_cnt), .fen(ctl_fen), .push_req(src_req),
    .rd_en(rd_en), .flush(tx_flush), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_irq(rx_irq), .rd_data(rd_data), .rx_stat(rx_stat)
);

// File: tb/uart_rx_fifo_bench.sv
module uart_rx_fifo_bench;
    localparam int DEPTH = 16;
    localparam int TRIG  = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, rx_brk = 0, lb_en = 0, tx_valid = 0;
    logic [7:0] rx_data = 0, tx_data = 0;
    logic [1:0] rx_err = 0;
    logic cfg_wr = 0, cfg_fifo_en = 0, rd_en = 0, stat_clr = 0, irq_clr = 0;
    logic rx_ready, rx_irq, rx_empty, rx_full, tx_flush;
    logic [11:0] rd_data;
    logic [3:0] rx_stat;

    int n_chk = 0, n_fail = 0;
    logic [11:0] q[$];
    bit fen_m = 0, irq_m = 0;
    logic [3:0] stat_m = 0;

    always #4 clk = ~clk;

    uart_rx_fifo #(.DEPTH(DEPTH), .TRIG(TRIG)) u_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .rx_brk(rx_brk), .lb_en(lb_en), .tx_valid(tx_valid),
        .tx_data(tx_data), .rx_ready(rx_ready), .cfg_wr(cfg_wr),
        .cfg_fifo_en(cfg_fifo_en), .rd_en(rd_en), .rd_data(rd_data),
        .stat_clr(stat_clr), .rx_stat(rx_stat), .irq_clr(irq_clr),
        .rx_irq(rx_irq), .rx_empty(rx_empty), .rx_full(rx_full), .tx_flush(tx_flush)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic idle();
        rx_valid = 0; rx_brk = 0; tx_valid = 0; cfg_wr = 0;
        rd_en = 0; stat_clr = 0; irq_clr = 0;
    endtask

    // one clock: check combinational outputs, step the model, check registered outputs
    task automatic cyc(input string tag);
        int dep;
        bit tog, pushq;
        logic [11:0] w, t;
        #1;
        dep = fen_m ? DEPTH : 1;
        tog = cfg_wr && (cfg_fifo_en != fen_m);
        chk(rx_ready === (q.size() < dep), tag, "rx_ready", int'(rx_ready), int'(q.size() < dep));
        chk(tx_flush === tog, tag, "tx_flush", int'(tx_flush), int'(tog));
        if (!tog && rd_en && q.size() > 0)
            chk(rd_data === q[0], tag, "rd_data", int'(rd_data), int'(q[0]));
        if (stat_clr) stat_m = 4'h0;
        if (irq_clr) irq_m = 1'b0;
        if (tog) begin
            q.delete();
            fen_m = cfg_fifo_en;
        end else begin
            if (rd_en) begin
                if (q.size() > 0) begin
                    stat_m = q[0][11:8];
                    void'(q.pop_front());
                end
                if (q.size() + 1 == TRIG) irq_m = 1'b0;
            end
            w = '0;
            if (lb_en) begin pushq = tx_valid; w = {4'h0, tx_data}; end
            else if (rx_brk) begin pushq = 1'b1; w = 12'h400; end
            else begin pushq = rx_valid; w = {2'b00, rx_err, rx_data}; end
            if (pushq) begin
                if (q.size() < dep) begin
                    q.push_back(w);
                    if (q.size() == TRIG) irq_m = 1'b1;
                end else begin
                    t = q[q.size()-1];
                    t[11] = 1'b1;
                    q[q.size()-1] = t;
                end
            end
        end
        @(posedge clk);
        #1;
        dep = fen_m ? DEPTH : 1;
        chk(rx_empty === (q.size() == 0), tag, "rx_empty", int'(rx_empty), int'(q.size() == 0));
        chk(rx_full === (q.size() == dep), tag, "rx_full", int'(rx_full), int'(q.size() == dep));
        chk(rx_irq === irq_m, tag, "rx_irq", int'(rx_irq), int'(irq_m));
        chk(rx_stat === stat_m, tag, "rx_stat", int'(rx_stat), int'(stat_m));
        @(negedge clk);
        idle();
    endtask

    task automatic push_rx(input logic [7:0] d, input logic [1:0] e, input string tag);
        rx_valid = 1; rx_data = d; rx_err = e;
        cyc(tag);
    endtask

    task automatic rd(input string tag);
        rd_en = 1;
        cyc(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(rx_empty === 1'b1, "R1", "rx_empty", int'(rx_empty), 1);
        chk(rx_full === 1'b0, "R1", "rx_full", int'(rx_full), 0);
        chk(rx_irq === 1'b0, "R1", "rx_irq", int'(rx_irq), 0);
        chk(rx_stat === 4'h0, "R1", "rx_stat", int'(rx_stat), 0);
        chk(rx_ready === 1'b1, "R1", "rx_ready", int'(rx_ready), 1);
        rst_n = 1;

        // single-entry mode: R2 capacity 1, R3 layout, R4 overrun mark
        push_rx(8'hA5, 2'b01, "R3");
        push_rx(8'h3C, 2'b00, "R4");
        rd("R5");                        // expects 0x9A5, status 0x9
        rd("R5 empty read");
        stat_clr = 1; cyc("R6");
        push_rx(8'h11, 2'b10, "R2");
        rd_en = 1; stat_clr = 1; cyc("R6 capture wins");

        // R8: enable FIFO mode (flush)
        cfg_wr = 1; cfg_fifo_en = 1; cyc("R8");
        for (int i = 0; i < DEPTH + 2; i++) push_rx(8'(i * 7), 2'(i), "R2 fill");
        irq_clr = 1; cyc("R7 clr");
        rx_valid = 1; rx_data = 8'hEE; rd_en = 1; cyc("R11 full");
        rx_valid = 1; rx_data = 8'hEF; irq_clr = 1; cyc("R4 full");
        for (int i = 0; i < DEPTH + 1; i++) rd("R5 drain");
        push_rx(8'h42, 2'b00, "R7 set");
        irq_clr = 1; rx_valid = 1; rx_data = 8'h43; cyc("R7 set wins");
        rd("R7"); rd("R7 drain");

        // R9 loopback, R10 break
        lb_en = 1; tx_valid = 1; tx_data = 8'h5A; rx_valid = 1; rx_data = 8'h01; cyc("R9");
        lb_en = 1; rx_brk = 1; cyc("R9 brk ignored");
        lb_en = 0;
        rx_brk = 1; rx_valid = 1; rx_data = 8'h77; cyc("R10");
        rd("R10"); rd("R9");

        // R8: repeated mode is harmless, toggle beats push/read
        push_rx(8'h21, 2'b11, "R8");
        cfg_wr = 1; cfg_fifo_en = 1; cyc("R8 same");
        push_rx(8'h22, 2'b00, "R8");
        cfg_wr = 1; cfg_fifo_en = 0; rx_valid = 1; rd_en = 1; cyc("R8 toggle");
        push_rx(8'h23, 2'b00, "R8");
        push_rx(8'h24, 2'b00, "R8");
        rd_en = 1; rx_valid = 1; rx_data = 8'h25; cyc("R11 depth1");
        rd("R5");

        // random traffic
        for (int i = 0; i < 1500; i++) begin
            rx_valid = $urandom_range(0, 1);
            rx_data = 8'($urandom);
            rx_err = 2'($urandom);
            rx_brk = ($urandom_range(0, 15) == 0);
            lb_en = ($urandom_range(0, 7) == 0);
            tx_valid = $urandom_range(0, 1);
            tx_data = 8'($urandom);
            rd_en = ($urandom_range(0, 2) == 0);
            stat_clr = ($urandom_range(0, 9) == 0);
            irq_clr = ($urandom_range(0, 5) == 0);
            cfg_wr = ($urandom_range(0, 40) == 0);
            cfg_fifo_en = ($urandom_range(0, 3) != 0);
            cyc("R3 random");
            lb_en = 0;
        end
        report();
    end
endmodule